// File: doc/BRIEF.md
# Windowed Alpha-Blend Overlay Channel

This block places one source pixel stream on top of an underlying layer inside a rectangular window of the output frame. Every clock it receives the current output coordinate, one source pixel (three 8-bit colour components plus an 8-bit alpha byte) and the underlying pixel. One clock later it presents the composited pixel.

Inside the window, and when the channel is enabled and selected, each colour component is computed as a weighted sum of the source and underlying components, divided by 255 and rounded. The weights come from two coefficient selects, and both can use a blend alpha. That alpha is the per-pixel alpha, the global alpha, or the two combined. The alpha mode is either programmed directly or derived from whether the source format carries alpha and from the global alpha value. Everywhere else the underlying pixel passes through unchanged.

The configuration inputs are static signals, normally driven from a register block elsewhere in the chip.

Top module: `ovl_blend_chan`

## Requirements
- R1: The window corners are packed with x in bits 31:16 and y in bits 15:0. Both corners are inclusive: a coordinate is inside when x0 <= posX <= x1 and y0 <= posY <= y1.
- R2: Outside the window, `outPix` equals `underPix` of the previous cycle.
- R3: The channel is active only when `chanEn` is 1 and `srcSel` equals CHAN_ID+1. Otherwise `outPix` equals `underPix` of the previous cycle.
- R4: With `alphaMode` 1 (per-pixel), the blend alpha `a` is the source alpha byte, `srcPix[31:24]`.
- R5: With `alphaMode` 2 (global), `a` is `globalAlpha`.
- R6: With `alphaMode` 3 (combined), `a` is (pixel alpha × globalAlpha + 127) / 255, with integer division.
- R7: With `alphaMode` 0 (automatic):
  - a source with alpha (`srcHasAlpha` = 1) uses per-pixel mode when `globalAlpha` is 255;
  - a source with alpha uses combined mode when `globalAlpha` is below 255;
  - a source without alpha uses global mode.
- R8: The coefficient select codes are 0 = zero, 1 = 255, 2 = 255−a and 3 = a. The normal setting is source code 3 and underlying code 2.
- R9: Each component of `srcPix[23:0]` and `underPix` (R in 23:16, G in 15:8, B in 7:0) is blended as min(255, (cs·src + cu·under + 127) / 255).
- R10: The output is registered, so the result appears one clock after its inputs. Reset drives `outPix` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| posX | input | 16 | Current output column |
| posY | input | 16 | Current output row |
| srcPix | input | 32 | Source pixel: alpha in 31:24, then R, G, B |
| srcHasAlpha | input | 1 | Source format carries an alpha byte |
| underPix | input | 24 | Underlying pixel, R, G, B |
| winTopLeft | input | 32 | Top-left corner {x, y}, inclusive |
| winBotRight | input | 32 | Bottom-right corner {x, y}, inclusive |
| srcSel | input | 3 | Source select, channel index plus one |
| chanEn | input | 1 | Channel enable |
| alphaMode | input | 2 | 0 automatic, 1 per-pixel, 2 global, 3 combined |
| srcCoefSel | input | 2 | Source coefficient select |
| undCoefSel | input | 2 | Underlying coefficient select |
| globalAlpha | input | 8 | Global alpha |
| outPix | output | 24 | Composited pixel |

## Verification
The assertions check the properties that hold on every cycle. They cover:
- pass-through of the underlying pixel outside the window;
- pass-through when the channel is disabled or not selected;
- a fully opaque and a fully transparent source under the normal coefficients;
- the zero state after reset.

The arithmetic needs the bench's scenarios. This covers the rounding of the combined alpha, the choice made by automatic mode at global alpha 255 and just below it, saturation when both coefficients are large, and the exact inclusive corner coordinates.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int PIX_W = 8;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  typedef enum logic [1:0] {
    MODE_AUTO = 2'd0,
    MODE_PIXEL = 2'd1,
    MODE_GLOBAL = 2'd2,
    MODE_COMBINED = 2'd3
  } alpha_mode_e;

  typedef enum logic [1:0] {
    COEF_ZERO = 2'd0,
    COEF_FULL = 2'd1,
    COEF_INV = 2'd2,
    COEF_ALPHA = 2'd3
  } coef_sel_e;

  typedef struct packed {
    logic blendOn;
    logic [PIX_W-1:0] coefSrc;
    logic [PIX_W-1:0] coefUnd;
  } ovl_strobe_t;
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int SEL_W = 3,
  parameter int CHAN_ID = 0
) (
  input logic [COORD_W-1:0] posX,
  input logic [COORD_W-1:0] posY,
  input logic [PIX_W-1:0] pixAlpha,
  input logic srcHasAlpha,
  input logic [2*COORD_W-1:0] winTopLeft,
  input logic [2*COORD_W-1:0] winBotRight,
  input logic [SEL_W-1:0] srcSel,
  input logic chanEn,
  input logic [1:0] alphaMode,
  input logic [1:0] srcCoefSel,
  input logic [1:0] undCoefSel,
  input logic [PIX_W-1:0] globalAlpha,
  output ovl_strobe_t strobe
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CHAN_ID + 1);
  localparam int PROD_W = 2 * PIX_W;

  logic [COORD_W-1:0] x0, y0, x1, y1;
  logic inWin;
  alpha_mode_e effMode;
  logic [PROD_W-1:0] combProd;
  logic [PIX_W-1:0] combAlpha, blendAlpha;

  assign x0 = winTopLeft[2*COORD_W-1:COORD_W];
  assign y0 = winTopLeft[COORD_W-1:0];
  assign x1 = winBotRight[2*COORD_W-1:COORD_W];
  assign y1 = winBotRight[COORD_W-1:0];
  assign inWin = (posX >= x0) && (posX <= x1) && (posY >= y0) && (posY <= y1);

  always_comb begin
    effMode = alpha_mode_e'(alphaMode);
    if (effMode == MODE_AUTO) begin
      if (!srcHasAlpha) effMode = MODE_GLOBAL;
      else if (globalAlpha == PIX_W'(PIX_MAX)) effMode = MODE_PIXEL;
      else effMode = MODE_COMBINED;
    end
  end

  assign combProd = pixAlpha * globalAlpha + PROD_W'(PIX_MAX / 2);
  assign combAlpha = PIX_W'(combProd / PROD_W'(PIX_MAX));

  always_comb begin
    case (effMode)
      MODE_PIXEL: blendAlpha = pixAlpha;
      MODE_GLOBAL: blendAlpha = globalAlpha;
      default: blendAlpha = combAlpha;
    endcase
  end

  function automatic logic [PIX_W-1:0] pickCoef(input logic [1:0] sel, input logic [PIX_W-1:0] a);
    case (coef_sel_e'(sel))
      COEF_ZERO: pickCoef = '0;
      COEF_FULL: pickCoef = PIX_W'(PIX_MAX);
      COEF_INV: pickCoef = PIX_W'(PIX_MAX) - a;
      default: pickCoef = a;
    endcase
  endfunction

  assign strobe.blendOn = inWin && chanEn && (srcSel == MY_SEL);
  assign strobe.coefSrc = pickCoef(srcCoefSel, blendAlpha);
  assign strobe.coefUnd = pickCoef(undCoefSel, blendAlpha);
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int NUM_COMP = 3
) (
  input logic clk,
  input logic rst,
  input ovl_strobe_t strobe,
  input logic [NUM_COMP*PIX_W-1:0] srcRgb,
  input logic [NUM_COMP*PIX_W-1:0] underRgb,
  output logic [NUM_COMP*PIX_W-1:0] outRgb
);
  localparam int SUM_W = 2 * PIX_W + 2;

  logic [NUM_COMP*PIX_W-1:0] blendRgb;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [SUM_W-1:0] wsum;
    logic [SUM_W-1:0] quot;
    assign wsum = SUM_W'(strobe.coefSrc * srcRgb[c*PIX_W +: PIX_W])
                + SUM_W'(strobe.coefUnd * underRgb[c*PIX_W +: PIX_W])
                + SUM_W'(PIX_MAX / 2);
    assign quot = wsum / SUM_W'(PIX_MAX);
    assign blendRgb[c*PIX_W +: PIX_W] = (quot > SUM_W'(PIX_MAX)) ? PIX_W'(PIX_MAX) : quot[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) outRgb <= '0;
    else outRgb <= strobe.blendOn ? blendRgb : underRgb;
  end
endmodule

// File: rtl/ovl_blend_chan.sv
module ovl_blend_chan
  import ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int SEL_W = 3,
  parameter int CHAN_ID = 0
) (
  input logic clk,
  input logic rst,
  input logic [COORD_W-1:0] posX,
  input logic [COORD_W-1:0] posY,
  input logic [4*PIX_W-1:0] srcPix,
  input logic srcHasAlpha,
  input logic [3*PIX_W-1:0] underPix,
  input logic [2*COORD_W-1:0] winTopLeft,
  input logic [2*COORD_W-1:0] winBotRight,
  input logic [SEL_W-1:0] srcSel,
  input logic chanEn,
  input logic [1:0] alphaMode,
  input logic [1:0] srcCoefSel,
  input logic [1:0] undCoefSel,
  input logic [PIX_W-1:0] globalAlpha,
  output logic [3*PIX_W-1:0] outPix
);
  ovl_strobe_t strobe;

  ovl_ctrl #(.COORD_W(COORD_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) u_ctrl (
    .posX(posX), .posY(posY), .pixAlpha(srcPix[4*PIX_W-1:3*PIX_W]),
    .srcHasAlpha(srcHasAlpha), .winTopLeft(winTopLeft), .winBotRight(winBotRight),
    .srcSel(srcSel), .chanEn(chanEn), .alphaMode(alphaMode),
    .srcCoefSel(srcCoefSel), .undCoefSel(undCoefSel), .globalAlpha(globalAlpha),
    .strobe(strobe)
  );

  ovl_datapath #(.NUM_COMP(3)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .srcRgb(srcPix[3*PIX_W-1:0]), .underRgb(underPix), .outRgb(outPix)
  );
endmodule

// File: rtl/ovl_blend_chan_chk.sv
module ovl_blend_chan_chk #(
  parameter int COORD_W = 16,
  parameter int SEL_W = 3,
  parameter int CHAN_ID = 0
) (
  input logic clk,
  input logic rst,
  input logic [COORD_W-1:0] posX,
  input logic [COORD_W-1:0] posY,
  input logic [31:0] srcPix,
  input logic [23:0] underPix,
  input logic [2*COORD_W-1:0] winTopLeft,
  input logic [2*COORD_W-1:0] winBotRight,
  input logic [SEL_W-1:0] srcSel,
  input logic chanEn,
  input logic [1:0] alphaMode,
  input logic [1:0] srcCoefSel,
  input logic [1:0] undCoefSel,
  input logic [23:0] outPix
);
  logic outside, inactive, normalPixel;
  assign outside = (posX < winTopLeft[2*COORD_W-1:COORD_W]) || (posX > winBotRight[2*COORD_W-1:COORD_W])
                || (posY < winTopLeft[COORD_W-1:0]) || (posY > winBotRight[COORD_W-1:0]);
  assign inactive = !chanEn || (srcSel != SEL_W'(CHAN_ID + 1));
  assign normalPixel = !outside && !inactive && alphaMode == 2'd1 && srcCoefSel == 2'd3 && undCoefSel == 2'd2;

  // R2
  pass_outside_chk: assert property (@(posedge clk) disable iff (rst)
    outside |=> outPix == $past(underPix));
  // R3
  pass_inactive_chk: assert property (@(posedge clk) disable iff (rst)
    inactive |=> outPix == $past(underPix));
  // R4
  opaque_src_chk: assert property (@(posedge clk) disable iff (rst)
    (normalPixel && srcPix[31:24] == 8'hFF) |=> outPix == $past(srcPix[23:0]));
  // R4
  clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    (normalPixel && srcPix[31:24] == 8'h00) |=> outPix == $past(underPix));
  // R10
  reset_zero_chk: assert property (@(posedge clk) rst |=> outPix == 24'h0);
endmodule

bind ovl_blend_chan ovl_blend_chan_chk #(.COORD_W(COORD_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) u_chk (
  .clk(clk), .rst(rst), .posX(posX), .posY(posY), .srcPix(srcPix), .underPix(underPix),
  .winTopLeft(winTopLeft), .winBotRight(winBotRight), .srcSel(srcSel), .chanEn(chanEn),
  .alphaMode(alphaMode), .srcCoefSel(srcCoefSel), .undCoefSel(undCoefSel), .outPix(outPix)
);

// File: tb/ovl_blend_chan_bench.sv
module ovl_blend_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [15:0] posX = 0, posY = 0;
  logic [31:0] srcPix = 0;
  logic srcHasAlpha = 0;
  logic [23:0] underPix = 0;
  logic [31:0] winTopLeft = {16'd10, 16'd20};
  logic [31:0] winBotRight = {16'd13, 16'd22};
  logic [2:0] srcSel = 3'd1;
  logic chanEn = 1;
  logic [1:0] alphaMode = 0, srcCoefSel = 2'd3, undCoefSel = 2'd2;
  logic [7:0] globalAlpha = 8'hFF;
  logic [23:0] outPix;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_blend_chan u_ovl_blend_chan (
    .clk(clk), .rst(rst), .posX(posX), .posY(posY), .srcPix(srcPix), .srcHasAlpha(srcHasAlpha),
    .underPix(underPix), .winTopLeft(winTopLeft), .winBotRight(winBotRight), .srcSel(srcSel),
    .chanEn(chanEn), .alphaMode(alphaMode), .srcCoefSel(srcCoefSel), .undCoefSel(undCoefSel),
    .globalAlpha(globalAlpha), .outPix(outPix)
  );

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] src;
    logic [23:0] und;
    logic hasA;
    logic [1:0] mode;
    logic [7:0] ga;
    logic [1:0] cs;
    logic [1:0] cu;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'd11, 16'd21, 32'hFF102030, 24'h405060, 1'b0, 2'd1, 8'hFF, 2'd3, 2'd2, 24'h102030}, // R4 opaque
    '{16'd11, 16'd21, 32'h00102030, 24'h405060, 1'b0, 2'd1, 8'hFF, 2'd3, 2'd2, 24'h405060}, // R4 clear
    '{16'd11, 16'd21, 32'h80FF0000, 24'h0000FF, 1'b0, 2'd1, 8'hFF, 2'd3, 2'd2, 24'h80007F}, // R4 half
    '{16'd12, 16'd22, 32'h00FF0000, 24'h0000FF, 1'b0, 2'd2, 8'h80, 2'd3, 2'd2, 24'h80007F}, // R5
    '{16'd12, 16'd22, 32'h80FF0000, 24'h000000, 1'b0, 2'd3, 8'h80, 2'd3, 2'd2, 24'h400000}, // R6
    '{16'd10, 16'd20, 32'hFFC8C8C8, 24'h000000, 1'b1, 2'd0, 8'hFF, 2'd3, 2'd2, 24'hC8C8C8}, // R7 pixel, R1 corner
    '{16'd13, 16'd22, 32'hFFFF0000, 24'h000000, 1'b1, 2'd0, 8'hFE, 2'd3, 2'd2, 24'hFE0000}, // R7 combined, R1 corner
    '{16'd11, 16'd21, 32'h00FF0000, 24'h000000, 1'b0, 2'd0, 8'h40, 2'd3, 2'd2, 24'h400000}, // R7 global
    '{16'd11, 16'd21, 32'h00C80000, 24'hC80000, 1'b0, 2'd1, 8'hFF, 2'd1, 2'd1, 24'hFF0000}, // R9 saturate
    '{16'd11, 16'd21, 32'hFF123456, 24'h654321, 1'b0, 2'd1, 8'hFF, 2'd0, 2'd0, 24'h000000}, // R8 zero
    '{16'd14, 16'd21, 32'hFF123456, 24'h654321, 1'b0, 2'd1, 8'hFF, 2'd3, 2'd2, 24'h654321}, // R1 x past corner
    '{16'd11, 16'd19, 32'hFF123456, 24'hABCDEF, 1'b0, 2'd1, 8'hFF, 2'd3, 2'd2, 24'hABCDEF}  // R2 above
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic applyVec(input vec_t v);
    posX = v.x; posY = v.y; srcPix = v.src; underPix = v.und; srcHasAlpha = v.hasA;
    alphaMode = v.mode; globalAlpha = v.ga; srcCoefSel = v.cs; undCoefSel = v.cu;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    underPix = 24'h777777; posX = 11; posY = 21;
    repeat (3) @(negedge clk);
    check("R10 reset", outPix, 24'h0);
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      applyVec(VEC[i]);
      @(negedge clk);
      check($sformatf("R9 vector %0d", i), outPix, VEC[i].exp);
    end
    // R3 disabled
    applyVec(VEC[0]); chanEn = 0;
    @(negedge clk);
    check("R3 disabled", outPix, 24'h405060);
    // R3 wrong select
    chanEn = 1; srcSel = 3'd2;
    @(negedge clk);
    check("R3 select", outPix, 24'h405060);
    srcSel = 3'd1;
    // R10 latency: output holds previous result until next edge
    applyVec(VEC[0]);
    @(negedge clk);
    underPix = 24'h010203; posX = 16'd30;
    @(posedge clk); #1;
    check("R10 latency", outPix, 24'h010203);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R10 reset again", outPix, 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule